// File: doc/BRIEF.md
# Windowed Framebuffer Address Generator

This block produces the byte address for each write into the frame store of a 4-bit grayscale display controller. Each byte holds two pixels. The frame store is 64 byte-columns wide and 80 rows tall, and it is addressed linearly as `column + row * 64`. The block holds a current column and a current row. Both stay inside a rectangular window that the command logic loads. The current address is shown combinationally, so the memory can take it in the same cycle as the write strobe. The position moves on the clock edge that ends an accepted write.

There are two advance orders. In horizontal order the column moves first: at the column limit it returns to the column start, and the row moves by one, wrapping to the row start at the row limit. In vertical order the roles swap: the row moves first, and the column steps when the row wraps. A limit is reached when the current value is at or beyond the end value. So a window whose start lies past its end returns to its start after every write on that axis. Every write also sets a dirty flag, which tells the scan-out side that the image has changed. The scan-out side clears the flag with a pulse.

Top module: `fbag_top`

## Requirements
- R1: After reset the position is column 0, row 0 (address 0), the column window is 0..63, the row window is 0..79, and dirty is 0. So 64 writes in horizontal order from reset reach address 64.
- R2: `byteAddr` always equals current column + current row * 64. It is valid in the same cycle as `wrStrobe`, and it is always below 5120.
- R3: In horizontal order (`vertMode`=0), a write moves the column to column+1 if the column is below the column end. Otherwise the column returns to the column start and the row advances.
- R4: In horizontal order, when the column wraps and the row is at or beyond the row end, the row returns to the row start. Otherwise the row goes to row+1.
- R5: In vertical order (`vertMode`=1), a write moves the row to row+1 if the row is below the row end. Otherwise the row returns to the row start and the column advances.
- R6: In vertical order, when the row wraps and the column is at or beyond the column end, the column returns to the column start. Otherwise the column goes to column+1.
- R7: A pulse on `colLoad` sets the current column and the column start to `colFirst` mod 64, and the column end to `colLast` mod 64. For example, 66 gives 2.
- R8: A pulse on `rowLoad` sets the current row and the row start to `rowFirst` mod 80, and the row end to `rowLast` mod 80. For example, 255 gives 15 and 200 gives 40.
- R9: When a load and a write occur in the same cycle, the write uses the old address and no position advance takes place. The loaded axis takes its new start, and an axis that is not loaded keeps its value.
- R10: A write sets `dirty` on the next edge. A `dirtyClr` pulse clears it on the next edge. If both occur in the same cycle, the write wins.
- R11: In a cycle with no write and no load, the address and `dirty` do not change, except that `dirtyClr` clears `dirty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | A data byte is being written at `byteAddr` this cycle |
| vertMode | input | 1 | 0: column-first order, 1: row-first order |
| colLoad | input | 1 | Load the column window from `colFirst`/`colLast` |
| colFirst | input | 8 | Column start argument (taken mod 64) |
| colLast | input | 8 | Column end argument (taken mod 64) |
| rowLoad | input | 1 | Load the row window from `rowFirst`/`rowLast` |
| rowFirst | input | 8 | Row start argument (taken mod 80) |
| rowLast | input | 8 | Row end argument (taken mod 80) |
| dirtyClr | input | 1 | Clear pulse from the scan-out logic |
| byteAddr | output | 13 | Linear frame-store byte address |
| dirty | output | 1 | The frame store has changed since the last clear |

## Verification
A wrong column or row register shows at once on `byteAddr`, the cycle after the bad edge, because the address is a direct function of the position. A wrong stored window start or end stays hidden until the position reaches a limit on that axis. For that reason the bench runs each order across both wraps of small windows, including a window whose start lies past its end. A wrong reduction of the load arguments appears on `byteAddr` in the first cycle after the load. A wrong end value appears at the first wrap that uses it.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  // Strobes from control to datapath, one group per axis.
  typedef struct packed {
    logic colLoad;
    logic colInc;
    logic colWrap;
    logic rowLoad;
    logic rowInc;
    logic rowWrap;
  } fbStrobe_t;
endpackage

// File: rtl/fbag_datapath.sv
module fbag_datapath
  import fbag_pkg::*;
#(
  parameter int COL_COUNT = 64,
  parameter int ROW_COUNT = 80,
  parameter int ARG_W     = 8,
  localparam int COL_W    = $clog2(COL_COUNT),
  localparam int ROW_W    = $clog2(ROW_COUNT),
  localparam int ADDR_W   = $clog2(COL_COUNT * ROW_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbStrobe_t         strobes,
  input  logic [ARG_W-1:0]  colArgA,
  input  logic [ARG_W-1:0]  colArgB,
  input  logic [ARG_W-1:0]  rowArgA,
  input  logic [ARG_W-1:0]  rowArgB,
  output logic              colAtEnd,
  output logic              rowAtEnd,
  output logic [ADDR_W-1:0] byteAddr
);
  localparam int MIN_COUNT = (COL_COUNT < ROW_COUNT) ? COL_COUNT : ROW_COUNT;
  localparam int MOD_STEPS = ((2 ** ARG_W) + MIN_COUNT - 1) / MIN_COUNT;
  localparam logic [ARG_W-1:0] COL_MOD = ARG_W'(COL_COUNT);
  localparam logic [ARG_W-1:0] ROW_MOD = ARG_W'(ROW_COUNT);

  // Reduce an argument by repeated conditional subtraction.
  function automatic logic [ARG_W-1:0] reduceArg(input logic [ARG_W-1:0] a,
                                                 input logic [ARG_W-1:0] m);
    logic [ARG_W-1:0] v;
    v = a;
    for (int i = 0; i < MOD_STEPS; i++) begin
      if (v >= m) v = v - m;
    end
    return v;
  endfunction

  logic [COL_W-1:0] col, colStart, colEnd;
  logic [ROW_W-1:0] row, rowStart, rowEnd;
  logic [ARG_W-1:0] colStartRed, colEndRed, rowStartRed, rowEndRed;

  always_comb begin
    colStartRed = reduceArg(colArgA, COL_MOD);
    colEndRed   = reduceArg(colArgB, COL_MOD);
    rowStartRed = reduceArg(rowArgA, ROW_MOD);
    rowEndRed   = reduceArg(rowArgB, ROW_MOD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      col      <= '0;
      colStart <= '0;
      colEnd   <= COL_W'(COL_COUNT - 1);
    end else if (strobes.colLoad) begin
      col      <= colStartRed[COL_W-1:0];
      colStart <= colStartRed[COL_W-1:0];
      colEnd   <= colEndRed[COL_W-1:0];
    end else if (strobes.colWrap) begin
      col <= colStart;
    end else if (strobes.colInc) begin
      col <= col + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row      <= '0;
      rowStart <= '0;
      rowEnd   <= ROW_W'(ROW_COUNT - 1);
    end else if (strobes.rowLoad) begin
      row      <= rowStartRed[ROW_W-1:0];
      rowStart <= rowStartRed[ROW_W-1:0];
      rowEnd   <= rowEndRed[ROW_W-1:0];
    end else if (strobes.rowWrap) begin
      row <= rowStart;
    end else if (strobes.rowInc) begin
      row <= row + ROW_W'(1);
    end
  end

  assign colAtEnd = (col >= colEnd);
  assign rowAtEnd = (row >= rowEnd);
  assign byteAddr = ADDR_W'(row) * ADDR_W'(COL_COUNT) + ADDR_W'(col);
endmodule

// File: rtl/fbag_control.sv
module fbag_control
  import fbag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStrobe,
  input  logic      vertMode,
  input  logic      colLoad,
  input  logic      rowLoad,
  input  logic      dirtyClr,
  input  logic      colAtEnd,
  input  logic      rowAtEnd,
  output fbStrobe_t strobes,
  output logic      dirty
);
  logic advance;
  logic leadWrap;

  // Any load in the cycle cancels the position advance.
  assign advance  = wrStrobe && !colLoad && !rowLoad;
  assign leadWrap = vertMode ? rowAtEnd : colAtEnd;

  always_comb begin
    strobes         = '0;
    strobes.colLoad = colLoad;
    strobes.rowLoad = rowLoad;
    if (advance) begin
      if (!vertMode) begin
        strobes.colInc  = !colAtEnd;
        strobes.colWrap = colAtEnd;
        strobes.rowInc  = leadWrap && !rowAtEnd;
        strobes.rowWrap = leadWrap && rowAtEnd;
      end else begin
        strobes.rowInc  = !rowAtEnd;
        strobes.rowWrap = rowAtEnd;
        strobes.colInc  = leadWrap && !colAtEnd;
        strobes.colWrap = leadWrap && colAtEnd;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         dirty <= 1'b0;
    else if (wrStrobe) dirty <= 1'b1;
    else if (dirtyClr) dirty <= 1'b0;
  end
endmodule

// File: rtl/fbag_top.sv
module fbag_top
  import fbag_pkg::*;
#(
  parameter int COL_COUNT = 64,
  parameter int ROW_COUNT = 80,
  parameter int ARG_W     = 8,
  localparam int ADDR_W   = $clog2(COL_COUNT * ROW_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              vertMode,
  input  logic              colLoad,
  input  logic [ARG_W-1:0]  colFirst,
  input  logic [ARG_W-1:0]  colLast,
  input  logic              rowLoad,
  input  logic [ARG_W-1:0]  rowFirst,
  input  logic [ARG_W-1:0]  rowLast,
  input  logic              dirtyClr,
  output logic [ADDR_W-1:0] byteAddr,
  output logic              dirty
);
  fbStrobe_t strobes;
  logic      colAtEnd;
  logic      rowAtEnd;

  fbag_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .vertMode (vertMode),
    .colLoad  (colLoad),
    .rowLoad  (rowLoad),
    .dirtyClr (dirtyClr),
    .colAtEnd (colAtEnd),
    .rowAtEnd (rowAtEnd),
    .strobes  (strobes),
    .dirty    (dirty)
  );

  fbag_datapath #(
    .COL_COUNT (COL_COUNT),
    .ROW_COUNT (ROW_COUNT),
    .ARG_W     (ARG_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .colArgA  (colFirst),
    .colArgB  (colLast),
    .rowArgA  (rowFirst),
    .rowArgB  (rowLast),
    .colAtEnd (colAtEnd),
    .rowAtEnd (rowAtEnd),
    .byteAddr (byteAddr)
  );
endmodule

// File: rtl/fbag_checker.sv
module fbag_checker #(
  parameter int COL_COUNT = 64,
  parameter int ROW_COUNT = 80,
  localparam int ADDR_W   = $clog2(COL_COUNT * ROW_COUNT)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic              vertMode,
  input logic              colLoad,
  input logic              rowLoad,
  input logic              dirtyClr,
  input logic              colAtEnd,
  input logic              rowAtEnd,
  input logic [ADDR_W-1:0] byteAddr,
  input logic              dirty
);
  localparam logic [ADDR_W-1:0] TOTAL = ADDR_W'(COL_COUNT * ROW_COUNT);

  p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteAddr < TOTAL);

  p_dirty_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> dirty);

  p_dirty_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dirtyClr && !wrStrobe) |=> !dirty);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrobe && !colLoad && !rowLoad) |=> $stable(byteAddr));

  p_horiz_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !vertMode && !colLoad && !rowLoad && !colAtEnd)
      |=> byteAddr == ADDR_W'($past(byteAddr) + ADDR_W'(1)));

  p_vert_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && vertMode && !colLoad && !rowLoad && !rowAtEnd)
      |=> byteAddr == ADDR_W'($past(byteAddr) + ADDR_W'(COL_COUNT)));
endmodule

bind fbag_top fbag_checker #(
  .COL_COUNT (COL_COUNT),
  .ROW_COUNT (ROW_COUNT)
) i_fbag_checker (
  .clk      (clk),
  .rstN     (rstN),
  .wrStrobe (wrStrobe),
  .vertMode (vertMode),
  .colLoad  (colLoad),
  .rowLoad  (rowLoad),
  .dirtyClr (dirtyClr),
  .colAtEnd (colAtEnd),
  .rowAtEnd (rowAtEnd),
  .byteAddr (byteAddr),
  .dirty    (dirty)
);

// File: tb/test_fbag_top.sv
`timescale 1ns/1ps
module test_fbag_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic        vertMode = 1'b0;
  logic        colLoad = 1'b0;
  logic [7:0]  colFirst = '0;
  logic [7:0]  colLast = '0;
  logic        rowLoad = 1'b0;
  logic [7:0]  rowFirst = '0;
  logic [7:0]  rowLast = '0;
  logic        dirtyClr = 1'b0;
  logic [12:0] byteAddr;
  logic        dirty;

  int checks = 0;
  int errors = 0;

  // Reference position and window built from the requirements.
  int mCol, mRow, mCs, mCe, mRs, mRe;
  bit mDirty;

  always #5 clk = ~clk;

  fbag_top i_fbag_top (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .vertMode(vertMode),
    .colLoad(colLoad), .colFirst(colFirst), .colLast(colLast),
    .rowLoad(rowLoad), .rowFirst(rowFirst), .rowLast(rowLast),
    .dirtyClr(dirtyClr), .byteAddr(byteAddr), .dirty(dirty)
  );

  task automatic check(input int actual, input int expected, input string req);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int expAddr();
    return mCol + mRow * 64;
  endfunction

  // Position advance per R3..R6.
  task automatic modelStep();
    if (!vertMode) begin
      if (mCol >= mCe) begin
        mCol = mCs;
        if (mRow >= mRe) mRow = mRs; else mRow++;
      end else mCol++;
    end else begin
      if (mRow >= mRe) begin
        mRow = mRs;
        if (mCol >= mCe) mCol = mCs; else mCol++;
      end else mRow++;
    end
  endtask

  // One cycle: drive on negedge, check address in the write cycle, then after the edge.
  task automatic cycle(input bit wr, input bit cl, input int c1, input int c2,
                       input bit rl, input int r1, input int r2, input bit clr,
                       input string req);
    @(negedge clk);
    wrStrobe = wr; colLoad = cl; colFirst = 8'(c1); colLast = 8'(c2);
    rowLoad = rl; rowFirst = 8'(r1); rowLast = 8'(r2); dirtyClr = clr;
    #1;
    if (wr) check(int'(byteAddr), expAddr(), {"R2 ", req});
    @(posedge clk);
    #1;
    wrStrobe = 0; colLoad = 0; rowLoad = 0; dirtyClr = 0;
    if (cl) begin mCs = c1 % 64; mCe = c2 % 64; mCol = mCs; end
    if (rl) begin mRs = r1 % 80; mRe = r2 % 80; mRow = mRs; end
    if (wr && !cl && !rl) modelStep();
    if (wr) mDirty = 1; else if (clr) mDirty = 0;
    check(int'(byteAddr), expAddr(), req);
    check(int'(dirty), int'(mDirty), {"R10 ", req});
  endtask

  task automatic doWrite(input string req);
    cycle(1, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic testReset();
    check(int'(byteAddr), 0, "R1 reset addr");
    check(int'(dirty), 0, "R1 reset dirty");
    vertMode = 0;
    for (int i = 0; i < 64; i++) doWrite("R1 default col window");
    check(int'(byteAddr), 64, "R1 after 64 writes");
  endtask

  task automatic testHorizontal();
    vertMode = 0;
    cycle(0, 1, 66, 4, 1, 3, 4, 0, "R7 col load mod");
    check(int'(byteAddr), 2 + 3 * 64, "R7 col start 66 -> 2");
    for (int i = 0; i < 7; i++) doWrite("R3 R4 horizontal wrap");
  endtask

  task automatic testVertical();
    vertMode = 1;
    cycle(0, 1, 10, 11, 1, 250, 12, 0, "R8 row load mod");
    check(int'(byteAddr), 10 + 10 * 64, "R8 row start 250 -> 10");
    for (int i = 0; i < 7; i++) doWrite("R5 R6 vertical wrap");
    cycle(0, 0, 0, 0, 1, 255, 200, 0, "R8 row 255 200");
    check(int'(byteAddr), mCol + 15 * 64, "R8 row start 255 -> 15");
    for (int i = 0; i < 27; i++) doWrite("R8 row end 200 -> 40");
  endtask

  task automatic testStartPastEnd();
    vertMode = 0;
    cycle(0, 1, 5, 2, 1, 0, 1, 0, "R7 reversed window load");
    for (int i = 0; i < 3; i++) doWrite("R3 R4 start past end");
    check(int'(byteAddr), 5 + 64, "R3 reversed window third write");
  endtask

  task automatic testLoadPriority();
    int rowBefore;
    vertMode = 0;
    cycle(0, 1, 0, 63, 1, 20, 30, 0, "R9 setup");
    doWrite("R9 setup write");
    doWrite("R9 setup write");
    rowBefore = mRow;
    cycle(1, 1, 7, 9, 0, 0, 0, 0, "R9 write with col load");
    check(int'(byteAddr), 7 + rowBefore * 64, "R9 load wins, row kept");
    cycle(1, 0, 0, 0, 1, 40, 41, 0, "R9 write with row load");
    check(int'(byteAddr), 7 + 40 * 64, "R9 col kept on row load");
  endtask

  task automatic testDirty();
    cycle(0, 0, 0, 0, 0, 0, 0, 1, "R10 clear");
    check(int'(dirty), 0, "R10 cleared");
    cycle(1, 0, 0, 0, 0, 0, 0, 1, "R10 write beats clear");
    check(int'(dirty), 1, "R10 set wins");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, "R10 clear again");
  endtask

  task automatic testIdle();
    int a0;
    a0 = int'(byteAddr);
    vertMode = 1;
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    check(int'(byteAddr), a0, "R11 address held");
    check(int'(dirty), 0, "R11 dirty held");
  endtask

  initial begin
    mCol = 0; mRow = 0; mCs = 0; mCe = 63; mRs = 0; mRe = 79; mDirty = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    testReset();
    testHorizontal();
    testVertical();
    testStartPastEnd();
    testLoadPriority();
    testDirty();
    testIdle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule